// File: doc/BRIEF.md
# Pipelined Multiplier Modulo 65537

This block multiplies two 16-bit words in the ring of integers modulo 2^16+1, which is the multiplicative group used by a well-known 64-bit block cipher. Because the modulus is prime and one larger than the word range, the value 2^16 has no 16-bit code of its own. The all-zero word stands for it, on both the operand and the result side. The block therefore never yields a true zero, and every word is a member of the group.

The datapath has two registered stages. A valid strobe travels alongside the data. The first stage forms the full 32-bit product. It also forms, on a separate short path, the answer for the uncommon case where an operand is the zero word. The second stage folds the product back into 16 bits. It subtracts the upper half from the lower half and adds one when that subtraction borrows. It then selects the zero-path answer when that path applies. A new operand pair may be accepted on every clock.

Top module: `mod65537_mul`

## Requirements
- R1: An operand word of 0 is taken as the value 65536, and a result value of 65536 is presented as the word 0.
- R2: For operands that are both nonzero, out_res equals (op_a × op_b) mod 65537. This is computed as lo − hi when lo ≥ hi and as lo − hi + 65537 otherwise, where lo and hi are the lower and upper 16 bits of the product, and the result is truncated to 16 bits.
- R3: When exactly one operand is 0, out_res equals (65537 − other operand) mod 65536.
- R4: When both operands are 0, out_res equals 1.
- R5: out_valid rises exactly two clock cycles after in_valid is sampled high, and out_res carries that operation's result in the same cycle.
- R6: Operations issued on consecutive cycles each produce their own correct result on consecutive cycles, in issue order.
- R7: While rst_n is low, and on the first edges after it is released, out_valid is 0.
- R8: An operand of 1 returns the other operand unchanged, including when the other operand is the zero word.
- R9: A cycle with in_valid low produces a cycle with out_valid low two cycles later, and no extra result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on op_a/op_b is valid this cycle |
| op_a | input | 16 | First operand, 0 means 65536 |
| op_b | input | 16 | Second operand, 0 means 65536 |
| out_valid | output | 1 | out_res holds a result |
| out_res | output | 16 | Product modulo 65537, 65536 shown as 0 |

## Verification
If a stage register held a stale or misaligned value, the wrong word would appear on out_res in the very cycle it should carry a result, two edges after issue. A fault in the valid pipe would show as a strobe that arrives one cycle early or late, or as a result that goes missing. Back-to-back and gapped streams expose both. A bad borrow correction changes only the products whose upper half exceeds the lower half, so random vectors reach it quickly. A bad zero-path select changes the corner words 0, 1 and 65535.

// File: rtl/mm_pkg.sv
package mm_pkg;
    // Default word width of the modular multiplier (modulus 2^W + 1)
    localparam int unsigned MM_W = 16;
    // Pipeline depth from operand capture to result
    localparam int unsigned MM_LAT = 2;
endpackage

// File: rtl/mm_prod_stage.sv
module mm_prod_stage #(
    parameter int unsigned W = mm_pkg::MM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic             s1_valid,
    output logic [2*W-1:0]   s1_prod,
    output logic             s1_zero,
    output logic [W-1:0]     s1_zres
);
    localparam int unsigned PW = 2 * W;
    localparam logic [PW-1:0] MAX_NZ_PROD = {{W{1'b1}}, {W{1'b0}}} - {{(W-1){1'b1}}, 1'b0} - {{(PW-1){1'b0}}, 1'b1};

    logic         a_zero;
    logic         b_zero;
    logic [W-1:0] other;
    logic [W-1:0] zres_d;

    // Zero path: (2^W)*x == -x (mod 2^W+1), so result = 1 - x truncated.
    // With both zero, other = 0 and the result is 1.
    always_comb begin
        a_zero = (a == '0);
        b_zero = (b == '0);
        other  = a_zero ? b : a;
        zres_d = W'(1) - other;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_prod  <= '0;
            s1_zero  <= 1'b0;
            s1_zres  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_prod <= PW'(a) * PW'(b);
                s1_zero <= a_zero | b_zero;
                s1_zres <= zres_d;
            end
        end
    end

    // R2
    // nonzero operands never give a product above (2^W-1)^2
    prod_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_zero) |-> (s1_prod <= MAX_NZ_PROD));
endmodule

// File: rtl/mm_reduce_stage.sv
module mm_reduce_stage #(
    parameter int unsigned W = mm_pkg::MM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  logic [2*W-1:0]   s1_prod,
    input  logic             s1_zero,
    input  logic [W-1:0]     s1_zres,
    output logic             out_valid,
    output logic [W-1:0]     out_res
);
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    logic [W:0]   diff;
    logic [W-1:0] folded;

    // lo - hi, plus (2^W + 1) on borrow, which is +1 after truncation
    always_comb begin
        lo     = s1_prod[W-1:0];
        hi     = s1_prod[2*W-1:W];
        diff   = {1'b0, lo} - {1'b0, hi};
        folded = diff[W] ? (diff[W-1:0] + W'(1)) : diff[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_res <= s1_zero ? s1_zres : folded;
            end
        end
    end
endmodule

// File: rtl/mod65537_mul.sv
module mod65537_mul #(
    parameter int unsigned W = mm_pkg::MM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_valid,
    output logic [W-1:0] out_res
);
    logic           s1_valid;
    logic [2*W-1:0] s1_prod;
    logic           s1_zero;
    logic [W-1:0]   s1_zres;

    mm_prod_stage #(.W(W)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .a        (op_a),
        .b        (op_b),
        .s1_valid (s1_valid),
        .s1_prod  (s1_prod),
        .s1_zero  (s1_zero),
        .s1_zres  (s1_zres)
    );

    mm_reduce_stage #(.W(W)) u_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_prod   (s1_prod),
        .s1_zero   (s1_zero),
        .s1_zres   (s1_zres),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R9
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R8
    identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == W'(1)) |-> ##2 (out_res == $past(op_b, 2)));

    // R4
    both_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == '0 && op_b == '0) |-> ##2 (out_res == W'(1)));
endmodule

// File: tb/tb_mod65537_mul.sv
module tb_mod65537_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        out_valid;
    logic [15:0] out_res;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] exp_q [0:1023];
    int          req_q [0:1023];
    int          head = 0;
    int          tail = 0;
    bit          mon_en = 0;

    always #4 clk = ~clk;

    mod65537_mul dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_res(out_res)
    );

    function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        longint unsigned av, bv, p;
        av = (a == 0) ? 65536 : a;
        bv = (b == 0) ? 65536 : b;
        p  = (av * bv) % 65537;
        return p[15:0];
    endfunction

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, expv);
        end
    endtask

    // Stream monitor: compares each result against the queued model value.
    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            if (head == tail) begin
                check(9, 32'(out_valid), 32'(0));
            end else begin
                check(req_q[head], 32'(out_res), 32'(exp_q[head]));
                head = head + 1;
            end
        end
    end

    task automatic push(input logic [15:0] a, input logic [15:0] b, input int req);
        in_valid = 1'b1;
        op_a = a;
        op_b = b;
        exp_q[tail] = ref_mul(a, b);
        req_q[tail] = req;
        tail = tail + 1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain(input int req);
        idle(4);
        check(req, 32'(tail - head), 32'(0));
        head = 0;
        tail = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(7, 32'(out_valid), 32'(0)); // R7 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(7, 32'(out_valid), 32'(0)); // R7 after release
    endtask

    task automatic t_latency;
        in_valid = 1'b1; op_a = 16'd3; op_b = 16'd5;
        @(negedge clk);
        in_valid = 1'b0;
        check(5, 32'(out_valid), 32'(0)); // R5 not yet after one edge
        @(negedge clk);
        check(5, 32'(out_valid), 32'(1)); // R5 valid after two edges
        check(5, 32'(out_res), 32'(15));
        @(negedge clk);
        check(5, 32'(out_valid), 32'(0));
    endtask

    task automatic t_corners;
        mon_en = 1;
        push(16'h0000, 16'h0000, 4);     // R4 both zero
        push(16'h0000, 16'h0001, 3);     // R3 -> 0
        push(16'h0001, 16'h0000, 8);     // R8 and R1 -> 0
        push(16'h0000, 16'h0002, 3);     // R3
        push(16'hFFFF, 16'h0000, 3);     // R3
        push(16'h0000, 16'h1234, 3);     // R3
        push(16'h0001, 16'h0001, 8);     // R8
        push(16'h0001, 16'hBEEF, 8);     // R8
        push(16'hFFFF, 16'hFFFF, 2);     // R2
        push(16'h8000, 16'h0002, 1);     // R1 result 65536 -> 0
        push(16'h0100, 16'h0100, 1);     // R1 result 65536 -> 0
        push(16'hFFFF, 16'h0002, 2);     // R2
        drain(9);
        mon_en = 0;
    endtask

    task automatic t_random;
        mon_en = 1;
        for (int i = 0; i < 400; i++) begin
            push(16'($urandom_range(1, 65535)), 16'($urandom_range(1, 65535)), 2); // R2
        end
        drain(6);
        mon_en = 0;
    endtask

    task automatic t_stream;
        mon_en = 1;
        for (int i = 0; i < 64; i++) begin
            push(16'(i * 1031 + 7), 16'(65535 - i * 977), 6); // R6 back-to-back
        end
        drain(6);
        mon_en = 0;
    endtask

    task automatic t_bubbles;
        mon_en = 1;
        for (int i = 0; i < 40; i++) begin
            push(16'($urandom), 16'($urandom), 9);
            if (i % 3 == 0) idle(1 + (i % 2)); // R9 gaps
        end
        drain(9);
        mon_en = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_corners();
        t_random();
        t_stream();
        t_bubbles();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule